// File: doc/BRIEF.md
# Power-Management Wake Event Controller

This block collects wake requests from four event sources (two ring-indicator lines, a keyboard and a mouse) and turns them into one active-low wake request output. Each source input goes through a two-flop synchronizer. A rising edge on a synchronized input sets that source's sticky wake-status bit. An enable mask picks which sources may request a wake. The combined request sets a sticky global status bit, and a global enable decides whether that status drives the wake output.

Software reaches the block through a byte-wide indexed register port with four registers: global control, global status, per-source wake status and per-source wake enable. Status bits are cleared by writing a one to them. A synchronous standby-power reset clears all state. A second reset, which stands for the main-power, soft and hard resets, clears only the registered read-data holding byte. The wake registers survive it, so a wake can be recorded and signalled while the main system is down.

Top module: `pmw_wake_ctrl`

## Requirements
- R1: While `sby_rst` is high at a clock edge, all four registers clear to 0x00 and `pme_n` goes to 1. After the reset is released, every register reads back 0x00.
- R2: `main_rst` leaves the contents of all four registers and the state of `pme_n` unchanged. Its only effect is to clear the `reg_rdata` holding byte to 0x00.
- R3: Index 0xC5 holds the global enable in bit 0. Bits 7:1 read 0 and ignore writes.
- R4: Index 0xC7 holds the wake status. Bit 1 is `wake_in[0]` (second ring indicator), bit 2 is `wake_in[1]` (first ring indicator), bit 3 is `wake_in[2]` (keyboard) and bit 4 is `wake_in[3]` (mouse). A bit sets on a synchronized rising edge of its source, whatever the enable bits are. Bits 0 and 7:5 read 0.
- R5: Writing 1 to a wake-status bit clears it, and writing 0 has no effect. If a source event and a clearing write reach the same bit in the same cycle, the bit stays set.
- R6: Index 0xC8 holds the wake enables, using the same bit positions as R4. They can be read and written. Bits 0 and 7:5 read 0 and ignore writes.
- R7: Index 0xC6 bit 0 (global status) sets on the clock after any source has both its status and its enable bit set. This happens even when the global enable is 0. Bits 7:1 read 0.
- R8: Writing 1 to global status bit 0 clears it and releases `pme_n` on that edge. If an enabled source still has its status set, the bit sets again on the next clock. Writing 0 has no effect.
- R9: `pme_n` is 0 exactly when the global enable and the global status are both 1.
- R10: Writes to indexes outside 0xC5–0xC8 change nothing, and reads of those indexes return 0x00.
- R11: `reg_rdata` updates on the clock edge that samples `reg_rd` high, and it holds that value until the next read or reset.
- R12: A source input held high produces only one event. After its status is cleared, the bit stays clear until the input goes low and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sby_rst | input | 1 | Synchronous standby-power reset, active high, clears all state |
| main_rst | input | 1 | Synchronous main-power/soft/hard reset, active high, clears only read holding byte |
| reg_idx | input | 8 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| wake_in | input | 4 | Asynchronous source wake lines (bit order as in R4) |
| pme_n | output | 1 | Active-low wake request |

## Verification
The bench lines up a source edge with a clearing write to the same status bit in the same cycle. A design where the clear has priority would lose the event and read back 0x00. It clears the global status while the wake condition is still present and checks that `pme_n` is released for exactly one cycle. A design with the wrong priority would never release the output or would never assert it again. It holds a source line high across a clear, which catches a design that detects levels instead of edges, because its status would set again. It also pulses `main_rst` while a wake is pending, which catches any register that wrongly sits in the main-power reset domain and would drop the wake.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

    localparam int DW       = 8;
    localparam int NSRC     = 4;
    localparam int SRC_LSB  = 1;
    localparam int SYNC_STG = 2;

    localparam logic [DW-1:0] IDX_CTRL = 8'hC5;
    localparam logic [DW-1:0] IDX_GSTS = 8'hC6;
    localparam logic [DW-1:0] IDX_WSTS = 8'hC7;
    localparam logic [DW-1:0] IDX_WEN  = 8'hC8;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_GSTS = 2'd1,
        SEL_WSTS = 2'd2,
        SEL_WEN  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_dec_t;

    function automatic reg_dec_t decode_idx(input logic [DW-1:0] idx);
        reg_dec_t d;
        d.hit = 1'b1;
        d.sel = SEL_CTRL;
        case (idx)
            IDX_CTRL: d.sel = SEL_CTRL;
            IDX_GSTS: d.sel = SEL_GSTS;
            IDX_WSTS: d.sel = SEL_WSTS;
            IDX_WEN:  d.sel = SEL_WEN;
            default:  d.hit = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic [DW-1:0] place_src(input logic [NSRC-1:0] v);
        logic [DW-1:0] r;
        r = '0;
        r[SRC_LSB +: NSRC] = v;
        return r;
    endfunction

    function automatic logic [NSRC-1:0] pick_src(input logic [DW-1:0] d);
        return d[SRC_LSB +: NSRC];
    endfunction

endpackage

// File: rtl/pmw_sync_edge.sv
module pmw_sync_edge
    import pmw_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] rise
);

    localparam int DEPTH = SYNC_STG + 1;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [DEPTH-1:0] sh;

        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[DEPTH-2:0], d_in[i]};
        end

        assign rise[i] = sh[SYNC_STG-1] & ~sh[SYNC_STG];

        assert_one_shot_R12: assert property (@(posedge clk) disable iff (rst)
            rise[i] |=> !rise[i]);
    end

endmodule

// File: rtl/pmw_regs.sv
module pmw_regs
    import pmw_pkg::*;
(
    input  logic            clk,
    input  logic            sby_rst,
    input  logic            main_rst,
    input  logic [DW-1:0]   idx,
    input  logic            wr,
    input  logic            rd,
    input  logic [DW-1:0]   wdata,
    input  logic [NSRC-1:0] evt,
    input  logic            gsts,
    output logic            gen,
    output logic [NSRC-1:0] wsts,
    output logic [NSRC-1:0] wen,
    output logic            gsts_clr,
    output logic [DW-1:0]   rdata
);

    reg_dec_t        dec;
    logic            wr_ctrl, wr_wsts, wr_wen;
    logic [NSRC-1:0] clr_mask;
    logic [DW-1:0]   rd_mux;
    logic            unused_wdata_hi;

    assign dec      = decode_idx(idx);
    assign wr_ctrl  = wr && dec.hit && (dec.sel == SEL_CTRL);
    assign wr_wsts  = wr && dec.hit && (dec.sel == SEL_WSTS);
    assign wr_wen   = wr && dec.hit && (dec.sel == SEL_WEN);
    assign gsts_clr = wr && dec.hit && (dec.sel == SEL_GSTS) && wdata[0];
    assign clr_mask = wr_wsts ? pick_src(wdata) : '0;
    assign unused_wdata_hi = ^wdata[DW-1:SRC_LSB+NSRC];

    always_ff @(posedge clk) begin
        if (sby_rst)      gen <= 1'b0;
        else if (wr_ctrl) gen <= wdata[0];
    end

    always_ff @(posedge clk) begin
        if (sby_rst) wsts <= '0;
        else         wsts <= (wsts & ~clr_mask) | evt;
    end

    always_ff @(posedge clk) begin
        if (sby_rst)     wen <= '0;
        else if (wr_wen) wen <= pick_src(wdata);
    end

    always_comb begin
        rd_mux = '0;
        if (dec.hit) begin
            case (dec.sel)
                SEL_CTRL: rd_mux[0] = gen;
                SEL_GSTS: rd_mux[0] = gsts;
                SEL_WSTS: rd_mux = place_src(wsts);
                SEL_WEN:  rd_mux = place_src(wen);
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (sby_rst || main_rst) rdata <= '0;
        else if (rd)             rdata <= rd_mux;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        assert_evt_wins_R5: assert property (@(posedge clk) disable iff (sby_rst)
            evt[i] |=> wsts[i]);
        assert_sticky_R5: assert property (@(posedge clk) disable iff (sby_rst)
            (wsts[i] && !(wr && idx == IDX_WSTS && wdata[SRC_LSB+i])) |=> wsts[i]);
    end

    assert_wen_keep_R2: assert property (@(posedge clk) disable iff (sby_rst)
        !(wr && idx == IDX_WEN) |=> $stable(wen));
    assert_ctrl_keep_R2: assert property (@(posedge clk) disable iff (sby_rst)
        !(wr && idx == IDX_CTRL) |=> $stable(gen));
    assert_oob_read_R10: assert property (@(posedge clk) disable iff (sby_rst)
        (rd && !main_rst && idx != IDX_CTRL && idx != IDX_GSTS &&
         idx != IDX_WSTS && idx != IDX_WEN) |=> (rdata == '0));
    assert_sby_clear_R1: assert property (@(posedge clk)
        sby_rst |=> (!gen && wsts == '0 && wen == '0 && rdata == '0));

endmodule

// File: rtl/pmw_wake_out.sv
module pmw_wake_out
    import pmw_pkg::*;
(
    input  logic            clk,
    input  logic            sby_rst,
    input  logic            gen,
    input  logic [NSRC-1:0] wsts,
    input  logic [NSRC-1:0] wen,
    input  logic            gsts_clr,
    output logic            gsts,
    output logic            pme_n
);

    logic cond;

    assign cond = |(wsts & wen);

    always_ff @(posedge clk) begin
        if (sby_rst)       gsts <= 1'b0;
        else if (gsts_clr) gsts <= 1'b0;
        else if (cond)     gsts <= 1'b1;
    end

    assign pme_n = ~(gen & gsts);

    assert_gsts_cause_R7: assert property (@(posedge clk) disable iff (sby_rst)
        $rose(gsts) |-> $past(cond));
    assert_gsts_clear_R8: assert property (@(posedge clk) disable iff (sby_rst)
        gsts_clr |=> !gsts);
    assert_gsts_hold_R8: assert property (@(posedge clk) disable iff (sby_rst)
        (gsts && !gsts_clr) |=> gsts);
    assert_pme_needs_gen_R9: assert property (@(posedge clk) disable iff (sby_rst)
        !gen |=> (pme_n || $past(gen) == 1'b0 && gen));

endmodule

// File: rtl/pmw_wake_ctrl.sv
module pmw_wake_ctrl
    import pmw_pkg::*;
(
    input  logic            clk,
    input  logic            sby_rst,
    input  logic            main_rst,
    input  logic [DW-1:0]   reg_idx,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NSRC-1:0] wake_in,
    output logic            pme_n
);

    logic [NSRC-1:0] evt;
    logic [NSRC-1:0] wsts, wen;
    logic            gen, gsts, gsts_clr;

    pmw_sync_edge #(.N(NSRC)) u_sync (
        .clk  (clk),
        .rst  (sby_rst),
        .d_in (wake_in),
        .rise (evt)
    );

    pmw_regs u_regs (
        .clk      (clk),
        .sby_rst  (sby_rst),
        .main_rst (main_rst),
        .idx      (reg_idx),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .wdata    (reg_wdata),
        .evt      (evt),
        .gsts     (gsts),
        .gen      (gen),
        .wsts     (wsts),
        .wen      (wen),
        .gsts_clr (gsts_clr),
        .rdata    (reg_rdata)
    );

    pmw_wake_out u_out (
        .clk      (clk),
        .sby_rst  (sby_rst),
        .gen      (gen),
        .wsts     (wsts),
        .wen      (wen),
        .gsts_clr (gsts_clr),
        .gsts     (gsts),
        .pme_n    (pme_n)
    );

    assert_main_keeps_pme_R2: assert property (@(posedge clk) disable iff (sby_rst)
        (main_rst && !reg_wr && !pme_n) |=> !pme_n);

endmodule

// File: tb/tb_pmw_wake_ctrl.sv
module tb_pmw_wake_ctrl;

    logic       clk = 1'b0;
    logic       sby_rst = 1'b1;
    logic       main_rst = 1'b0;
    logic [7:0] reg_idx = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] wake_in = '0;
    logic       pme_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pmw_wake_ctrl dut (
        .clk(clk), .sby_rst(sby_rst), .main_rst(main_rst),
        .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wake_in(wake_in), .pme_n(pme_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] i, input logic [7:0] d);
        reg_idx = i; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] i, output logic [7:0] d);
        reg_idx = i; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse_src(input int s);
        wake_in[s] = 1'b1;
        idle(4);
        wake_in[s] = 1'b0;
        idle(3);
    endtask

    task automatic do_sby_reset();
        sby_rst = 1'b1;
        idle(2);
        sby_rst = 1'b0;
        idle(1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_sby_reset();
        chk("R1 pme_n", {7'd0, pme_n}, 8'h01);
        bus_read(8'hC5, v); chk("R1 ctrl", v, 8'h00);
        bus_read(8'hC6, v); chk("R1 gsts", v, 8'h00);
        bus_read(8'hC7, v); chk("R1 wsts", v, 8'h00);
        bus_read(8'hC8, v); chk("R1 wen", v, 8'h00);
    endtask

    task automatic t_ctrl_wen();
        logic [7:0] v;
        bus_write(8'hC5, 8'hFF);
        bus_read(8'hC5, v); chk("R3 ctrl reserved", v, 8'h01);
        bus_write(8'hC5, 8'h00);
        bus_read(8'hC5, v); chk("R3 ctrl clear", v, 8'h00);
        bus_write(8'hC8, 8'hFF);
        bus_read(8'hC8, v); chk("R6 wen mask", v, 8'h1E);
        bus_write(8'hC8, 8'h0A);
        bus_read(8'hC8, v); chk("R6 wen pattern", v, 8'h0A);
        bus_write(8'hC8, 8'h00);
    endtask

    task automatic t_sources();
        logic [7:0] v;
        for (int s = 0; s < 4; s++) begin
            pulse_src(s);
            bus_read(8'hC7, v); chk("R4 source bit", v, 8'(1 << (s + 1)));
            chk("R4 no pme when disabled", {7'd0, pme_n}, 8'h01);
            bus_write(8'hC7, 8'h00);
            bus_read(8'hC7, v); chk("R5 write 0 no effect", v, 8'(1 << (s + 1)));
            bus_write(8'hC7, 8'(1 << (s + 1)));
            bus_read(8'hC7, v); chk("R5 write 1 clears", v, 8'h00);
        end
        bus_read(8'hC6, v); chk("R7 no gsts without enable", v, 8'h00);
    endtask

    task automatic t_global();
        logic [7:0] v;
        bus_write(8'hC8, 8'h04);
        pulse_src(1);
        idle(1);
        bus_read(8'hC6, v); chk("R7 gsts with gen off", v, 8'h01);
        chk("R9 pme held off by gen", {7'd0, pme_n}, 8'h01);
        bus_write(8'hC5, 8'h01);
        chk("R9 pme asserted", {7'd0, pme_n}, 8'h00);
        bus_write(8'hC6, 8'h00);
        chk("R8 write 0 no effect", {7'd0, pme_n}, 8'h00);
        bus_write(8'hC6, 8'h01);
        chk("R8 release on clear", {7'd0, pme_n}, 8'h01);
        @(negedge clk);
        chk("R8 re-set next clock", {7'd0, pme_n}, 8'h00);
        bus_write(8'hC7, 8'h04);
        idle(1);
        chk("R8 gsts sticky", {7'd0, pme_n}, 8'h00);
        bus_write(8'hC6, 8'h01);
        idle(1);
        bus_read(8'hC6, v); chk("R8 gsts cleared", v, 8'h00);
        chk("R9 pme released", {7'd0, pme_n}, 8'h01);
        bus_write(8'hC5, 8'h00);
        bus_write(8'hC8, 8'h00);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        wake_in[3] = 1'b1;
        idle(2);
        bus_write(8'hC7, 8'h10);
        bus_read(8'hC7, v); chk("R5 event wins over clear", v, 8'h10);
        wake_in[3] = 1'b0;
        idle(3);
        bus_write(8'hC7, 8'h10);
        bus_read(8'hC7, v); chk("R5 later clear", v, 8'h00);
    endtask

    task automatic t_level();
        logic [7:0] v;
        wake_in[2] = 1'b1;
        idle(4);
        bus_read(8'hC7, v); chk("R12 first event", v, 8'h08);
        bus_write(8'hC7, 8'h08);
        idle(6);
        bus_read(8'hC7, v); chk("R12 held level no re-set", v, 8'h00);
        wake_in[2] = 1'b0;
        idle(3);
        wake_in[2] = 1'b1;
        idle(4);
        bus_read(8'hC7, v); chk("R12 new edge sets", v, 8'h08);
        wake_in[2] = 1'b0;
        bus_write(8'hC7, 8'h08);
    endtask

    task automatic t_oob();
        logic [7:0] v;
        bus_write(8'hC4, 8'hFF);
        bus_write(8'hC9, 8'hFF);
        bus_read(8'hC5, v); chk("R10 ctrl untouched", v, 8'h00);
        bus_read(8'hC8, v); chk("R10 wen untouched", v, 8'h00);
        bus_read(8'hC4, v); chk("R10 read low oob", v, 8'h00);
        bus_read(8'hC9, v); chk("R10 read high oob", v, 8'h00);
    endtask

    task automatic t_read_hold();
        logic [7:0] v;
        bus_write(8'hC8, 8'h12);
        reg_idx = 8'hC8; reg_rd = 1'b1;
        @(posedge clk);
        #1 chk("R11 data after read edge", reg_rdata, 8'h12);
        @(negedge clk);
        reg_rd = 1'b0;
        reg_idx = 8'hC5;
        idle(3);
        chk("R11 data holds", reg_rdata, 8'h12);
        bus_write(8'hC8, 8'h00);
        bus_read(8'hC8, v);
    endtask

    task automatic t_main_reset();
        logic [7:0] v;
        bus_write(8'hC5, 8'h01);
        bus_write(8'hC8, 8'h1E);
        pulse_src(3);
        idle(1);
        chk("R9 pme before main reset", {7'd0, pme_n}, 8'h00);
        bus_read(8'hC8, v);
        main_rst = 1'b1;
        idle(3);
        main_rst = 1'b0;
        chk("R2 rdata cleared", reg_rdata, 8'h00);
        chk("R2 pme kept", {7'd0, pme_n}, 8'h00);
        bus_read(8'hC5, v); chk("R2 ctrl kept", v, 8'h01);
        bus_read(8'hC6, v); chk("R2 gsts kept", v, 8'h01);
        bus_read(8'hC7, v); chk("R2 wsts kept", v, 8'h10);
        bus_read(8'hC8, v); chk("R2 wen kept", v, 8'h1E);
    endtask

    task automatic t_sby_again();
        logic [7:0] v;
        do_sby_reset();
        chk("R1 pme after standby reset", {7'd0, pme_n}, 8'h01);
        bus_read(8'hC5, v); chk("R1 ctrl cleared", v, 8'h00);
        bus_read(8'hC6, v); chk("R1 gsts cleared", v, 8'h00);
        bus_read(8'hC7, v); chk("R1 wsts cleared", v, 8'h00);
        bus_read(8'hC8, v); chk("R1 wen cleared", v, 8'h00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_ctrl_wen();
        t_sources();
        t_global();
        t_collision();
        t_level();
        t_oob();
        t_read_hold();
        t_main_reset();
        t_sby_again();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule